// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Datapath

This block is the arithmetic core of a small signal-processing engine. A 16-bit operand register holds one multiplier input. A signed 16x16 multiplier writes its 32-bit result into a dedicated product register. A 32-bit adder then folds that product, after a programmable left shift, into a 32-bit accumulator. The product register is a pipeline stage of its own. Because of it, one operation can add the previous product into the accumulator while a new multiplier operand is loaded or a new product is formed in the same cycle. A sum of products therefore takes about one cycle per term.

The block is controlled one operation per clock through a 4-bit opcode, a 5-bit shift field and an operand-source bit. The second multiplier input comes either from the data bus or from a program-side constant bus. The accumulator is read out through a left shifter of 0 to 7 bits, one 16-bit half per store operation. Zero, negative and sticky overflow flags report the state of the accumulator.

The opcode decoder is organised as a set of named operations, each selected in one `unique case` arm:
- NOP (0): idle.
- CLRA (1): clear the accumulator.
- LDT (2): load the operand register.
- MUL (3): multiply into the product register.
- ADDP (4): add the shifted product.
- ADDLD (5): add the shifted product and load the operand register.
- STH (6): store the high half.
- STL (7): store the low half.
- MAC (8): add the shifted product and multiply in the same cycle.

Every operation completes in the clock edge that samples it; the block has no other state sequencing.

Top module: `mac_datapath`

## Requirements
- R1: After reset the accumulator, operand and product registers are zero, `data_out` is 0, `flag_zero` is 1, and `flag_neg` and `flag_ovf` are 0.
- R2: LDT (opcode 2) loads `data_in` into the operand register. MUL (opcode 3) writes the signed product of the operand register and the second operand into the product register. The second operand is `data_in` when `op_src`=0 and `prog_in` when `op_src`=1.
- R3: ADDP (opcode 4) adds the product register into the accumulator, modulo 2^32, after shifting it left by `op_shift` bits. Shift values above 16 act as 16.
- R4: ADDLD (opcode 5) performs the ADDP addition using the old product and, in the same cycle, loads `data_in` into the operand register.
- R5: CLRA (opcode 1) sets the accumulator to zero and clears `flag_ovf`.
- R6: STH (opcode 6) and STL (opcode 7) shift the full 32-bit accumulator left by `op_shift[2:0]`. Opcode bit 0 then selects a half: 0 gives bits 31:16 and 1 gives bits 15:0. That half appears on `data_out` one cycle later and is held until the next store.
- R7: `flag_ovf` is set by any addition whose signed 32-bit result overflows. It stays set until CLRA or reset.
- R8: `flag_zero` is 1 exactly when the accumulator is zero, and `flag_neg` equals accumulator bit 31.
- R9: MAC (opcode 8) adds the old shifted product into the accumulator and, in the same cycle, writes a new product into the product register.
- R10: NOP, LDT, MUL, STH, STL and unused opcodes (9 to 15) leave the accumulator and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 4 | Operation select |
| op_shift | input | 5 | Product shift (0..16) or store shift (low 3 bits) |
| op_src | input | 1 | Second multiplier operand: 0 data bus, 1 program bus |
| data_in | input | 16 | Data bus operand |
| prog_in | input | 16 | Program-side constant operand |
| data_out | output | 16 | Stored accumulator half |
| flag_zero | output | 1 | Accumulator equals zero |
| flag_neg | output | 1 | Accumulator sign bit |
| flag_ovf | output | 1 | Sticky signed overflow |

## Verification
The bench sweeps every pair from a set of extreme operands (0, ±1, the most positive and most negative values). These pairs catch a multiplier that treats operands as unsigned, or that mishandles the product of the two most negative values. Four-term sums of products are run through both the add-and-load sequence and the add-and-multiply sequence. A design that added the new product instead of the old one, or that loaded the operand a cycle late, would give the wrong total. Product shifts are swept over 0 to 31, so a shifter that does not saturate at 16 shows up. Store shifts are swept over 0 to 7 for both halves, so a shift applied after the half is selected shows up. A repeated addition that crosses the sign boundary checks that the overflow flag is set, stays set, and is cleared only by clearing the accumulator.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int unsigned OPW = 16;
    localparam int unsigned ACCW = 2 * OPW;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_CLRA  = 4'd1,
        OP_LDT   = 4'd2,
        OP_MUL   = 4'd3,
        OP_ADDP  = 4'd4,
        OP_ADDLD = 4'd5,
        OP_STH   = 4'd6,
        OP_STL   = 4'd7,
        OP_MAC   = 4'd8
    } mac_op_e;
endpackage

// File: rtl/mac_lshift.sv
module mac_lshift #(
    parameter int unsigned W     = 32,
    parameter int unsigned SHW   = 5,
    parameter int unsigned MAXSH = 16
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] sh,
    output logic [W-1:0]   dout
);
    logic [SHW-1:0] sh_eff;
    logic [W-1:0]   stage [SHW+1];

    // shift amounts above the limit saturate at the limit
    assign sh_eff   = (sh > SHW'(MAXSH)) ? SHW'(MAXSH) : sh;
    assign stage[0] = din;

    // barrel shifter: stage i shifts by 2**i when bit i of the amount is set
    for (genvar i = 0; i < SHW; i++) begin : g_stage
        assign stage[i+1] = sh_eff[i] ? (stage[i] << (2 ** i)) : stage[i];
    end

    assign dout = stage[SHW];
endmodule

// File: rtl/mac_product.sv
module mac_product #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          t_load,
    input  logic [DW-1:0] t_din,
    input  logic          mul_en,
    input  logic [DW-1:0] operand,
    output logic [2*DW-1:0] p_out
);
    localparam int unsigned PW = 2 * DW;

    logic [DW-1:0] t_q;
    logic [PW-1:0] p_q;
    logic signed [PW-1:0] prod;

    assign prod = $signed(t_q) * $signed(operand);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
            p_q <= '0;
        end else begin
            if (t_load) t_q <= t_din;
            if (mul_en) p_q <= prod;
        end
    end

    assign p_out = p_q;

    AST_T_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !t_load |=> $stable(t_q)); // R2
    AST_P_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mul_en |=> $stable(p_q)); // R9
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add_en,
    input  logic [W-1:0] addend,
    output logic [W-1:0] acc,
    output logic         ovf
);
    logic [W-1:0] acc_q;
    logic [W-1:0] sum;
    logic         ovf_q;
    logic         ovf_now;

    assign sum     = acc_q + addend;
    assign ovf_now = (acc_q[W-1] == addend[W-1]) && (sum[W-1] != acc_q[W-1]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else if (add_en) begin
            acc_q <= sum;
            ovf_q <= ovf_q | ovf_now;
        end
    end

    assign acc = acc_q;
    assign ovf = ovf_q;

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !add_en) |=> ($stable(acc_q) && $stable(ovf_q))); // R10
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(add_en)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr) |=> ovf_q); // R7
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0 && !ovf_q)); // R5
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
#(
    parameter int unsigned DW      = 16,
    parameter int unsigned SHW     = 5,
    parameter int unsigned PMAXSH  = 16,
    parameter int unsigned SSHW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_code,
    input  logic [SHW-1:0] op_shift,
    input  logic          op_src,
    input  logic [DW-1:0] data_in,
    input  logic [DW-1:0] prog_in,
    output logic [DW-1:0] data_out,
    output logic          flag_zero,
    output logic          flag_neg,
    output logic          flag_ovf
);
    localparam int unsigned AW     = 2 * DW;
    localparam int unsigned SSMAX  = (1 << SSHW) - 1;

    mac_op_e       op;
    logic          t_load, mul_en, clr, add_en, st_en, st_low;
    logic [DW-1:0] operand;
    logic [AW-1:0] p_val, p_shifted, acc, acc_shifted;
    logic [DW-1:0] dout_q;

    assign op      = mac_op_e'(op_code);
    assign operand = op_src ? prog_in : data_in;

    // operation decode
    always_comb begin
        t_load = 1'b0;
        mul_en = 1'b0;
        clr    = 1'b0;
        add_en = 1'b0;
        st_en  = 1'b0;
        st_low = op_code[0];
        unique case (op)
            OP_CLRA:  clr = 1'b1;
            OP_LDT:   t_load = 1'b1;
            OP_MUL:   mul_en = 1'b1;
            OP_ADDP:  add_en = 1'b1;
            OP_ADDLD: begin add_en = 1'b1; t_load = 1'b1; end
            OP_STH, OP_STL: st_en = 1'b1;
            OP_MAC:   begin add_en = 1'b1; mul_en = 1'b1; end
            default:  ;
        endcase
    end

    mac_product #(.DW(DW)) u_product (
        .clk(clk), .rst_n(rst_n),
        .t_load(t_load), .t_din(data_in),
        .mul_en(mul_en), .operand(operand),
        .p_out(p_val)
    );

    mac_lshift #(.W(AW), .SHW(SHW), .MAXSH(PMAXSH)) u_pshift (
        .din(p_val), .sh(op_shift), .dout(p_shifted)
    );

    mac_accum #(.W(AW)) u_accum (
        .clk(clk), .rst_n(rst_n),
        .clr(clr), .add_en(add_en), .addend(p_shifted),
        .acc(acc), .ovf(flag_ovf)
    );

    mac_lshift #(.W(AW), .SHW(SSHW), .MAXSH(SSMAX)) u_sshift (
        .din(acc), .sh(op_shift[SSHW-1:0]), .dout(acc_shifted)
    );

    // store path register
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_q <= '0;
        else if (st_en)
            dout_q <= st_low ? acc_shifted[DW-1:0] : acc_shifted[AW-1:DW];
    end

    assign data_out  = dout_q;
    assign flag_zero = (acc == '0);
    assign flag_neg  = acc[AW-1];

    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(op == OP_STH || op == OP_STL) |=> $stable(data_out)); // R6
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLRA) |=> (flag_zero && !flag_neg && !flag_ovf)); // R5
    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NOP || op == OP_LDT || op == OP_MUL || op == OP_STH || op == OP_STL)
        |=> ($stable(flag_zero) && $stable(flag_neg) && $stable(flag_ovf))); // R10
    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        flag_zero |-> !flag_neg); // R8
endmodule

// File: tb/test_mac_datapath.sv
module test_mac_datapath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [4:0]  op_shift = 5'd0;
    logic        op_src = 1'b0;
    logic [15:0] data_in = '0;
    logic [15:0] prog_in = '0;
    logic [15:0] data_out;
    logic        flag_zero, flag_neg, flag_ovf;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mac_datapath i_mac_datapath (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_shift(op_shift),
        .op_src(op_src), .data_in(data_in), .prog_in(prog_in),
        .data_out(data_out), .flag_zero(flag_zero), .flag_neg(flag_neg),
        .flag_ovf(flag_ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one operation at a falling edge; returns at the next falling edge
    task automatic op(input logic [3:0] c, input logic [4:0] s, input logic src,
                      input logic [15:0] d, input logic [15:0] pg);
        op_code = c; op_shift = s; op_src = src; data_in = d; prog_in = pg;
        @(negedge clk);
        op_code = 4'd0;
    endtask

    task automatic read_acc(output logic [31:0] v);
        op(4'd6, 5'd0, 1'b0, 16'h0, 16'h0);
        v[31:16] = data_out;
        op(4'd7, 5'd0, 1'b0, 16'h0, 16'h0);
        v[15:0] = data_out;
    endtask

    function automatic logic [31:0] mulx(input logic [15:0] a, input logic [15:0] b);
        longint pa = longint'($signed(a));
        longint pb = longint'($signed(b));
        return 32'(pa * pb);
    endfunction

    function automatic bit ovf_of(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] s = a + b;
        return (a[31] == b[31]) && (s[31] != a[31]);
    endfunction

    // four-term sum of products; use_mac selects the add-and-multiply form (R9) or add-and-load (R4)
    task automatic sop(input logic [15:0] x[4], input logic [15:0] c[4], input bit use_mac);
        logic [31:0] exp_acc = 0, got;
        bit exp_ovf = 0;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] p = mulx(x[i], c[i]);
            exp_ovf = exp_ovf | ovf_of(exp_acc, p);
            exp_acc = exp_acc + p;
        end
        op(4'd1, 0, 0, 0, 0);
        op(4'd2, 0, 0, x[0], 0);
        op(4'd3, 0, 0, c[0], 0);
        for (int i = 1; i < 4; i++) begin
            if (use_mac) begin
                op(4'd2, 0, 0, x[i], 0);
                op(4'd8, 0, 1, 16'hDEAD, c[i]);
            end else begin
                op(4'd5, 0, 0, x[i], 0);
                op(4'd3, 0, 1, 16'hBEEF, c[i]);
            end
        end
        op(4'd4, 0, 0, 0, 0);
        chk(use_mac ? "R9 mac sum of products ovf" : "R4 add-load sum of products ovf",
            32'(flag_ovf), 32'(exp_ovf));
        read_acc(got);
        chk(use_mac ? "R9 mac sum of products" : "R4 add-load sum of products", got, exp_acc);
    endtask

    initial begin
        logic [15:0] corner[8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                                   16'h8000, 16'h1234, 16'hEDCB, 16'h00FF};
        logic [31:0] v, pv, base;
        logic [15:0] xs[4], cs[4];

        repeat (3) @(negedge clk);
        chk("R1 reset data_out", 32'(data_out), 0);
        chk("R1 reset zero", 32'(flag_zero), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset zero", 32'(flag_zero), 1);
        chk("R1 after reset neg", 32'(flag_neg), 0);
        chk("R1 after reset ovf", 32'(flag_ovf), 0);
        chk("R1 after reset data_out", 32'(data_out), 0);
        op(4'd4, 0, 0, 0, 0);
        read_acc(v);
        chk("R1 product register clear", v, 0);
        op(4'd3, 0, 0, 16'h7777, 0);
        op(4'd4, 0, 0, 0, 0);
        read_acc(v);
        chk("R1 operand register clear", v, 0);

        // R2: exhaustive corner pairs, both operand sources
        foreach (corner[i]) foreach (corner[j]) begin
            logic s = 1'((i + j) % 2);
            op(4'd1, 0, 0, 0, 0);
            op(4'd2, 0, 0, corner[i], 0);
            op(4'd3, 0, s, s ? 16'h5A5A : corner[j], s ? corner[j] : 16'h5A5A);
            op(4'd4, 0, 0, 0, 0);
            read_acc(v);
            chk("R2 multiply corner pair", v, mulx(corner[i], corner[j]));
            chk("R8 zero flag", 32'(flag_zero), 32'(v == 0));
            chk("R8 neg flag", 32'(flag_neg), 32'(v[31]));
        end

        // R3: product shift sweep with saturation at 16
        op(4'd2, 0, 0, 16'hFFFD, 0);
        op(4'd3, 0, 0, 16'h0101, 0);
        pv = mulx(16'hFFFD, 16'h0101);
        for (int s = 0; s < 32; s++) begin
            op(4'd1, 0, 0, 0, 0);
            op(4'd4, 5'(s), 0, 0, 0);
            read_acc(v);
            chk("R3 product shift", v, pv << ((s > 16) ? 16 : s));
        end

        // R6: store shift sweep on both halves
        op(4'd1, 0, 0, 0, 0);
        op(4'd2, 0, 0, 16'h1357, 0);
        op(4'd3, 0, 0, 16'h2468, 0);
        op(4'd4, 0, 0, 0, 0);
        base = mulx(16'h1357, 16'h2468);
        for (int s = 0; s < 8; s++) begin
            op(4'd6, 5'(s) | 5'b11000, 0, 0, 0);
            chk("R6 store high half shifted", 32'(data_out), 32'(base << s) >> 16);
            op(4'd7, 5'(s), 0, 0, 0);
            chk("R6 store low half shifted", 32'(data_out), 32'((base << s) & 32'hFFFF));
            op(4'd0, 0, 0, 0, 0);
            chk("R6 data_out held", 32'(data_out), 32'((base << s) & 32'hFFFF));
        end

        // R10: non-accumulating and unused opcodes leave the accumulator alone
        for (int c = 9; c < 16; c++) op(4'(c), 5'd3, 1, 16'hFFFF, 16'hFFFF);
        op(4'd2, 0, 0, 16'h0003, 0);
        op(4'd3, 0, 0, 16'h0003, 0);
        read_acc(v);
        chk("R10 unused and non-add ops ignored", v, base);

        // R7/R5: overflow set, sticky, then cleared
        op(4'd1, 0, 0, 0, 0);
        op(4'd2, 0, 0, 16'h8000, 0);
        op(4'd3, 0, 0, 16'h8000, 0);
        op(4'd4, 0, 0, 0, 0);
        chk("R7 no overflow at 2^30", 32'(flag_ovf), 0);
        op(4'd4, 0, 0, 0, 0);
        chk("R7 overflow at 2^31", 32'(flag_ovf), 1);
        chk("R8 neg after wrap", 32'(flag_neg), 1);
        op(4'd4, 0, 0, 0, 0);
        chk("R7 overflow sticky", 32'(flag_ovf), 1);
        read_acc(v);
        chk("R3 wrapped accumulator", v, 32'hC000_0000);
        op(4'd1, 0, 0, 0, 0);
        chk("R5 clear drops overflow", 32'(flag_ovf), 0);
        chk("R5 clear sets zero", 32'(flag_zero), 1);

        // R4/R9: sums of products, extreme then random
        xs = '{16'h8000, 16'h8000, 16'h8000, 16'h8000};
        cs = '{16'h8000, 16'h8000, 16'h8000, 16'h8000};
        sop(xs, cs, 0);
        sop(xs, cs, 1);
        for (int n = 0; n < 150; n++) begin
            for (int k = 0; k < 4; k++) begin
                xs[k] = 16'($urandom);
                cs[k] = 16'($urandom);
            end
            sop(xs, cs, 0);
            sop(xs, cs, 1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule